// File: doc/BRIEF.md
# Immediate Trap Compare and Interrupt Entry

This block watches a stream of 32-bit instruction words and acts on the trap-word-immediate form. It compares a 32-bit operand value against the instruction's 16-bit immediate, after the immediate has been sign-extended to 32 bits. A 5-bit condition field in the word chooses which relations are tested: signed less, signed greater, equal, unsigned less and unsigned greater. If any chosen relation holds, the block enters a program interrupt in a single clock edge. At that edge it saves the trapping instruction's address and the current machine state, writes a syndrome that marks a trap, clears a fixed set of machine-state bits, and produces a redirect PC.

The redirect PC is built from two registers held inside the block: a vector prefix register and a program-interrupt offset register. Each has its own write port. The machine-state register also has a write port, so the surrounding core can load it. The trap-taken pulse and the redirect PC appear in the cycle after the qualifying instruction is presented. An instruction that does not trap changes no state.

Top module: `trap_imm_unit`

## Requirements
- R1: The word is decoded in big-endian numbering, with bit 0 as the most significant bit. The opcode is in bits 0:5 (`insn_word[31:26]`) and must equal 3. The condition field is in bits 6:10 (`[25:21]`), the register index in bits 11:15 (`[20:16]`), and the immediate in bits 16:31 (`[15:0]`). A word is ignored if `insn_valid` is low or if its opcode is not 3.
- R2: The immediate is sign-extended to 32 bits before any comparison, so an immediate of 0xFFFF compares equal to an operand of 0xFFFFFFFF.
- R3: Each condition bit enables one test:
  - `insn_word[25]`: signed less-than.
  - `[24]`: signed greater-than.
  - `[23]`: equal.
  - `[22]`: unsigned less-than.
  - `[21]`: unsigned greater-than.

  A trap is taken when any enabled test is true. `trap_taken` is then high for exactly the one cycle after the instruction is presented.
- R4: When no trap is taken, `save_pc`, `save_msr`, `syndrome`, `msr_q` and `redirect_pc` keep their values, except that `msr_q` still follows its own write port.
- R5: On a trap, `save_pc` receives the address of the trapping instruction itself.
- R6: On a trap, `save_msr` receives the machine-state value as it was before any bit is cleared.
- R7: On a trap, `syndrome` is set to 0x02000000. This is big-endian bit 6 alone, with every other bit cleared.
- R8: On a trap, the machine-state bits at big-endian positions 13, 16, 17, 18, 20, 21, 23, 26 and 27 are cleared. All other machine-state bits are kept.
- R9: On a trap, `redirect_pc` is built from three parts, in this order:
  - The prefix register bits `[31:16]`.
  - The offset register bits `[15:4]`.
  - Four zero bits.
- R10: After reset, every output and every internal register reads zero.
- R11: When a trap and a machine-state write fall in the same cycle, the trap wins: the write is dropped. When a trap and a prefix or offset write fall in the same cycle, the vector uses the register values from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is presented this cycle |
| insn_word | input | 32 | Instruction word |
| src_value | input | 32 | Operand register value |
| insn_addr | input | 32 | Address of the presented instruction |
| msr_wr_en | input | 1 | Machine-state register write enable |
| msr_wr_data | input | 32 | Machine-state register write value |
| vpfx_wr_en | input | 1 | Vector prefix register write enable |
| vpfx_wr_data | input | 32 | Vector prefix register write value |
| voff_wr_en | input | 1 | Program-interrupt offset register write enable |
| voff_wr_data | input | 32 | Program-interrupt offset register write value |
| trap_taken | output | 1 | One-cycle pulse that marks a trap entry |
| redirect_pc | output | 32 | Interrupt vector address |
| save_pc | output | 32 | Saved address of the trapping instruction |
| save_msr | output | 32 | Saved machine state |
| syndrome | output | 32 | Exception syndrome |
| msr_q | output | 32 | Current machine-state register |

## Verification
Two functions can fall in the same cycle: trap entry, and a register write through the machine-state, prefix or offset ports. The bench provokes this by presenting a trapping word on the same clock edge as a machine-state write and a prefix write. For the machine-state write, it judges that the saved state holds the old value and that the live state is the cleared old value, not the written one. For the prefix write, it judges that the vector uses the old prefix, and it confirms with a second trap that the new prefix did land.

// File: rtl/trap_imm_unit.sv
module trap_imm_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [31:0] insn_word,
  input  logic [31:0] src_value,
  input  logic [31:0] insn_addr,
  input  logic        msr_wr_en,
  input  logic [31:0] msr_wr_data,
  input  logic        vpfx_wr_en,
  input  logic [31:0] vpfx_wr_data,
  input  logic        voff_wr_en,
  input  logic [31:0] voff_wr_data,
  output logic        trap_taken,
  output logic [31:0] redirect_pc,
  output logic [31:0] save_pc,
  output logic [31:0] save_msr,
  output logic [31:0] syndrome,
  output logic [31:0] msr_q
);

  localparam logic [5:0]  OPC_TRAPI = 6'd3;
  localparam logic [31:0] SYND_TRAP = 32'h0200_0000;
  // cleared state bits, big-endian 13,16,17,18,20,21,23,26,27
  localparam logic [31:0] MSR_CLR = (32'h1 << 18) | (32'h1 << 15) | (32'h1 << 14) |
                                    (32'h1 << 13) | (32'h1 << 11) | (32'h1 << 10) |
                                    (32'h1 << 8)  | (32'h1 << 5)  | (32'h1 << 4);

  logic [31:0] vpfx_q, voff_q;

  wire [5:0]  opc     = insn_word[31:26];
  wire [4:0]  cond    = insn_word[25:21];
  wire [31:0] imm_ext = {{16{insn_word[15]}}, insn_word[15:0]};

  wire s_lt = $signed(src_value) < $signed(imm_ext);
  wire s_gt = $signed(src_value) > $signed(imm_ext);
  wire eq   = src_value == imm_ext;
  wire u_lt = src_value < imm_ext;
  wire u_gt = src_value > imm_ext;

  wire [4:0] hits = cond & {s_lt, s_gt, eq, u_lt, u_gt};
  wire       fire = insn_valid && (opc == OPC_TRAPI) && (hits != 5'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_taken  <= 1'b0;
      redirect_pc <= '0;
      save_pc     <= '0;
      save_msr    <= '0;
      syndrome    <= '0;
      msr_q       <= '0;
      vpfx_q      <= '0;
      voff_q      <= '0;
    end else begin
      trap_taken <= fire;
      if (fire) begin
        save_pc     <= insn_addr;
        save_msr    <= msr_q;
        syndrome    <= SYND_TRAP;
        msr_q       <= msr_q & ~MSR_CLR;
        redirect_pc <= {vpfx_q[31:16], voff_q[15:4], 4'b0000};
      end else if (msr_wr_en) begin
        msr_q <= msr_wr_data;
      end
      if (vpfx_wr_en) vpfx_q <= vpfx_wr_data;
      if (voff_wr_en) voff_q <= voff_wr_data;
    end
  end

  assert_ignore_other_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!insn_valid) || $past(insn_word[31:26]) != OPC_TRAPI) |-> !trap_taken);

  assert_zero_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(insn_word[25:21]) == 5'd0) |-> !trap_taken);

  assert_hold_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_taken |-> ($stable(save_pc) && $stable(save_msr) && $stable(syndrome) && $stable(redirect_pc)));

  assert_save_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> save_pc == $past(insn_addr));

  assert_save_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> save_msr == $past(msr_q));

  assert_syndrome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> $countones(syndrome) == 1 && syndrome[25]);

  assert_clear_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> ((msr_q & MSR_CLR) == '0) && ((msr_q & ~MSR_CLR) == (save_msr & ~MSR_CLR)));

endmodule

// File: tb/test_trap_imm_unit.sv
module test_trap_imm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = '0, src_value = '0, insn_addr = '0;
  logic        msr_wr_en = 1'b0, vpfx_wr_en = 1'b0, voff_wr_en = 1'b0;
  logic [31:0] msr_wr_data = '0, vpfx_wr_data = '0, voff_wr_data = '0;
  logic        trap_taken;
  logic [31:0] redirect_pc, save_pc, save_msr, syndrome, msr_q;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trap_imm_unit i_trap_imm_unit (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .src_value(src_value), .insn_addr(insn_addr),
    .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
    .vpfx_wr_en(vpfx_wr_en), .vpfx_wr_data(vpfx_wr_data),
    .voff_wr_en(voff_wr_en), .voff_wr_data(voff_wr_data),
    .trap_taken(trap_taken), .redirect_pc(redirect_pc), .save_pc(save_pc),
    .save_msr(save_msr), .syndrome(syndrome), .msr_q(msr_q));

  function automatic logic [31:0] clr_mask();
    logic [31:0] m = '0;
    int be [9] = '{13, 16, 17, 18, 20, 21, 23, 26, 27};
    foreach (be[i]) m[31 - be[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] to, input logic [15:0] imm);
    return {6'd3, to, 5'd7, imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_regs(input logic [31:0] m, input logic [31:0] p, input logic [31:0] o);
    @(negedge clk);
    msr_wr_en = 1; msr_wr_data = m; vpfx_wr_en = 1; vpfx_wr_data = p;
    voff_wr_en = 1; voff_wr_data = o;
    @(negedge clk);
    msr_wr_en = 0; vpfx_wr_en = 0; voff_wr_en = 0;
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] v, input logic [31:0] a);
    @(negedge clk);
    insn_valid = 1; insn_word = w; src_value = v; insn_addr = a;
    @(posedge clk); #1;
    @(negedge clk) insn_valid = 0;
  endtask

  // single-instruction outcome: trap_taken sampled 1ns after the capture edge
  task automatic expect_trap(input string req, input logic [31:0] w, input logic [31:0] v,
                             input bit exp_trap);
    logic [31:0] pc0 = save_pc, st0 = save_msr, m0 = msr_q, r0 = redirect_pc;
    @(negedge clk);
    insn_valid = 1; insn_word = w; src_value = v; insn_addr = 32'h0000_4A00;
    @(posedge clk); #1;
    chk({req, " trap_taken"}, {31'b0, trap_taken}, {31'b0, exp_trap});
    if (!exp_trap) begin
      chk("R4 save_pc held", save_pc, pc0);
      chk("R4 save_msr held", save_msr, st0);
      chk("R4 msr held", msr_q, m0);
      chk("R4 redirect held", redirect_pc, r0);
    end
    @(negedge clk) insn_valid = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 trap_taken", {31'b0, trap_taken}, 0);
    chk("R10 redirect_pc", redirect_pc, 0);
    chk("R10 save_pc", save_pc, 0);
    chk("R10 save_msr", save_msr, 0);
    chk("R10 syndrome", syndrome, 0);
    chk("R10 msr", msr_q, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic t_full_entry();
    wr_regs(32'hFFFF_FFFF, 32'hABCD_1234, 32'h0000_5A5F);
    issue(mk(5'b00100, 16'h0010), 32'h0000_0010, 32'h0001_2340);
    chk("R3 pulse", {31'b0, trap_taken}, 1);
    chk("R5 save_pc", save_pc, 32'h0001_2340);
    chk("R6 save_msr", save_msr, 32'hFFFF_FFFF);
    chk("R7 syndrome", syndrome, 32'h0200_0000);
    chk("R8 msr cleared", msr_q, 32'hFFFF_FFFF & ~clr_mask());
    chk("R9 redirect_pc", redirect_pc, 32'hABCD_5A50);
    @(posedge clk); #1;
    chk("R3 one-cycle pulse", {31'b0, trap_taken}, 0);
  endtask

  task automatic t_conditions();
    // -5 vs 3: signed less and unsigned greater are true
    expect_trap("R3 slt", mk(5'b10000, 16'd3), 32'hFFFF_FFFB, 1);
    expect_trap("R3 sgt false", mk(5'b01000, 16'd3), 32'hFFFF_FFFB, 0);
    expect_trap("R3 eq false", mk(5'b00100, 16'd3), 32'hFFFF_FFFB, 0);
    expect_trap("R3 ult false", mk(5'b00010, 16'd3), 32'hFFFF_FFFB, 0);
    expect_trap("R3 ugt", mk(5'b00001, 16'd3), 32'hFFFF_FFFB, 1);
    expect_trap("R3 sgt", mk(5'b01000, 16'd3), 32'd9, 1);
    expect_trap("R3 ult", mk(5'b00010, 16'd3), 32'd1, 1);
    expect_trap("R3 no enable", mk(5'b00000, 16'd3), 32'd3, 0);
    expect_trap("R3 mixed mask", mk(5'b11010, 16'd3), 32'd3, 0);
  endtask

  task automatic t_sign_ext();
    expect_trap("R2 eq sign-extended", mk(5'b00100, 16'hFFFF), 32'hFFFF_FFFF, 1);
    expect_trap("R2 not zero-extended", mk(5'b00100, 16'hFFFF), 32'h0000_FFFF, 0);
    expect_trap("R2 signed less neg imm", mk(5'b10000, 16'h8000), 32'h8000_0000, 1);
  endtask

  task automatic t_ignored();
    expect_trap("R1 opcode 31", {6'd31, 5'b11111, 5'd0, 16'h0}, 32'd0, 0);
    @(negedge clk);
    insn_valid = 0; insn_word = mk(5'b11111, 16'h0); src_value = 0;
    @(posedge clk); #1;
    chk("R1 valid low", {31'b0, trap_taken}, 0);
  endtask

  task automatic t_same_cycle();
    wr_regs(32'h0000_00FF, 32'h1111_0000, 32'h0000_0220);
    @(negedge clk);
    insn_valid = 1; insn_word = mk(5'b00100, 16'd0); src_value = 0; insn_addr = 32'h0000_8000;
    msr_wr_en = 1; msr_wr_data = 32'h1234_5678; vpfx_wr_en = 1; vpfx_wr_data = 32'h7777_0000;
    @(posedge clk); #1;
    chk("R11 save_msr old", save_msr, 32'h0000_00FF);
    chk("R11 msr write dropped", msr_q, 32'h0000_00FF & ~clr_mask());
    chk("R11 old prefix used", redirect_pc, 32'h1111_0220);
    @(negedge clk);
    insn_valid = 0; msr_wr_en = 0; vpfx_wr_en = 0;
    issue(mk(5'b00100, 16'd0), 32'd0, 32'h0000_8004);
    chk("R11 new prefix landed", redirect_pc, 32'h7777_0220);
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_full_entry();
    t_conditions();
    t_sign_ext();
    t_ignored();
    t_same_cycle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule